// File: doc/BRIEF.md
# Banked Multi-Core Interrupt Distributor

This block collects interrupt sources for a group of processor cores and presents each core with its single most urgent deliverable interrupt. Interrupt numbers below 32 are private: every core owns a separate copy of their pending, active, enable and priority state. Numbers 0 to 15 are raised only by software through the configuration port. Numbers 16 to 31 come from per-core peripheral lines. Numbers from 32 upward are shared peripheral interrupts. Each has one copy of its state and a route field that steers it to exactly one core.

Each core takes an interrupt by pulsing its acknowledge line. It then reads back the interrupt number, which moves from pending to active. The core signals completion by pulsing its end-of-interrupt line together with that number. A configuration write port sets enables, priorities, routes and per-core thresholds, and raises software interrupts. Arbitration is registered, so the number a core reads reflects the state of the previous cycle. The block re-checks that number against current state before handing it out.

Top module: `irq_dist`

## Requirements
- R1: Number map: 0–15 are software interrupts; 16+k is bit k of a core's 16-bit private line group (`ppi_in[core*16+k]`); 32+j is shared line `spi_in[j]`, for j below NUM_SPI (default 32, numbers 32–63).
- R2: Private numbers are banked. Raising, acknowledging or completing number n (n<32) on one core leaves number n on every other core unchanged.
- R3: A write with `cfg_op`=3 and `cfg_id` 0–15 sets that number pending on every core n for which `cfg_data[n]`=1. The same operation with `cfg_id` of 16 or more has no effect.
- R4: `cfg_op`=2 writes the low log2(NUM_PE) bits of `cfg_data` as the route of shared number `cfg_id`. Only the routed core sees a shared interrupt. A route change moves a pending shared interrupt to the new core.
- R5: Among candidates (pending, enabled, not active), the numerically lowest 8-bit priority wins, and equal priorities go to the lower number. `cfg_op`=1 writes priority `cfg_data` for `cfg_id`. For numbers below 32 the write goes to the bank of core `cfg_pe`.
- R6: An acknowledge with a valid number clears pending and sets active at the same edge. An active number is not a candidate and is never returned twice. An end-of-interrupt with that number clears active.
- R7: When a core has no live candidate, `ack_id` reads 1023. An acknowledge then changes no state.
- R8: `irq[n]` is high only while core n has a live candidate whose priority is numerically below the core's threshold. `cfg_op`=4 writes `cfg_data` as the threshold of core `cfg_pe`.
- R9: A rising input is captured as pending at the next clock edge and appears on `ack_id`/`irq` after the following edge. Directly after an acknowledge edge, that core's `ack_id` reads 1023.
- R10: `cfg_op`=0 writes `cfg_data[0]` as the enable of `cfg_id` (banked by `cfg_pe` below 32). A disabled interrupt is never a candidate. Writes to numbers at or above 32+NUM_SPI are ignored.
- R11: A shared interrupt's active state is cleared by an end-of-interrupt carrying its number from any core. Rerouting it while active does not block that completion.
- R12: After reset nothing is pending, active or enabled, priorities are 0, thresholds are 255, every `ack_id` reads 1023 and every `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Operation: 0 enable, 1 priority, 2 route, 3 software interrupt, 4 threshold |
| cfg_pe | input | log2(NUM_PE) | Core bank for private numbers and thresholds |
| cfg_id | input | 10 | Interrupt number |
| cfg_data | input | max(NUM_PE,8) | Write data or target core mask |
| ppi_in | input | NUM_PE*16 | Private peripheral lines, 16 per core |
| spi_in | input | NUM_SPI | Shared peripheral lines |
| ack | input | NUM_PE | Per-core acknowledge pulse |
| ack_id | output | NUM_PE*10 | Per-core number an acknowledge takes (1023 when none) |
| eoi | input | NUM_PE | Per-core end-of-interrupt pulse |
| eoi_id | input | NUM_PE*10 | Per-core number being completed |
| irq | output | NUM_PE | Per-core interrupt request |

## Verification
On every cycle, the assertions check that each `ack_id` is either 1023 or a number the block implements. They also check that `irq` never rises without a live number, that a number just taken is not offered again on the next cycle, and that a zero threshold silences a core's request. Banking independence, software-interrupt fan-out, route steering, priority and tie order, and completion from a different core after a reroute can only be shown by the bench's scenarios. The bench compares every core's outputs against a model of the requirements after each operation.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    localparam int LOCAL_IDS = 32;
    localparam int SGI_IDS   = 16;
    localparam int PPI_IDS   = LOCAL_IDS - SGI_IDS;
    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [2:0] {
        CFG_ENABLE = 3'd0,
        CFG_PRIO   = 3'd1,
        CFG_ROUTE  = 3'd2,
        CFG_SGI    = 3'd3,
        CFG_THRESH = 3'd4
    } cfg_op_e;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } cand_t;

endpackage

// File: rtl/irq_bank.sv
module irq_bank import irq_dist_pkg::*; #(
    parameter int DW = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  cfg_op_e                       cfg_op,
    input  logic                          cfg_sel,
    input  logic                          sgi_tgt,
    input  logic [ID_W-1:0]               cfg_id,
    input  logic [DW-1:0]                 cfg_data,
    input  logic [PPI_IDS-1:0]            ppi_in,
    input  logic                          take,
    input  logic [ID_W-1:0]               take_id,
    input  logic                          eoi,
    input  logic [ID_W-1:0]               eoi_id,
    output logic [LOCAL_IDS-1:0]          elig_o,
    output logic [LOCAL_IDS*PRIO_W-1:0]   prio_o
);
    logic [LOCAL_IDS-1:0]             pend, act, en;
    logic [LOCAL_IDS-1:0][PRIO_W-1:0] prio;
    logic [PPI_IDS-1:0]               ppi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            act   <= '0;
            en    <= '0;
            prio  <= '0;
            ppi_q <= '0;
        end else begin
            ppi_q <= ppi_in;
            for (int k = 0; k < LOCAL_IDS; k++) begin
                if (cfg_we && cfg_sel && cfg_id == ID_W'(k)) begin
                    case (cfg_op)
                        CFG_ENABLE: en[k]   <= cfg_data[0];
                        CFG_PRIO:   prio[k] <= cfg_data[PRIO_W-1:0];
                        default: ;
                    endcase
                end
                if (eoi && eoi_id == ID_W'(k)) act[k] <= 1'b0;
                if (take && take_id == ID_W'(k)) begin
                    pend[k] <= 1'b0;
                    act[k]  <= 1'b1;
                end
            end
            // new requests win over a same-cycle acknowledge
            for (int k = 0; k < SGI_IDS; k++) begin
                if (cfg_we && cfg_op == CFG_SGI && sgi_tgt && cfg_id == ID_W'(k))
                    pend[k] <= 1'b1;
            end
            for (int k = 0; k < PPI_IDS; k++) begin
                if (ppi_in[k] && !ppi_q[k]) pend[SGI_IDS+k] <= 1'b1;
            end
        end
    end

    assign elig_o = pend & en & ~act;
    assign prio_o = prio;

endmodule

// File: rtl/irq_shared.sv
module irq_shared import irq_dist_pkg::*; #(
    parameter int NUM_PE  = 8,
    parameter int NUM_SPI = 32,
    parameter int PE_W    = 3,
    parameter int DW      = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  cfg_op_e                     cfg_op,
    input  logic [ID_W-1:0]             cfg_id,
    input  logic [DW-1:0]               cfg_data,
    input  logic [NUM_SPI-1:0]          spi_in,
    input  logic [NUM_PE-1:0]           take,
    input  logic [NUM_PE*ID_W-1:0]      take_id,
    input  logic [NUM_PE-1:0]           eoi,
    input  logic [NUM_PE*ID_W-1:0]      eoi_id,
    output logic [NUM_SPI-1:0]          elig_o,
    output logic [NUM_SPI*PRIO_W-1:0]   prio_o,
    output logic [NUM_SPI*PE_W-1:0]     route_o
);
    logic [NUM_SPI-1:0]             pend, act, en, in_q;
    logic [NUM_SPI-1:0][PRIO_W-1:0] prio;
    logic [NUM_SPI-1:0][PE_W-1:0]   route;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            act   <= '0;
            en    <= '0;
            prio  <= '0;
            route <= '0;
            in_q  <= '0;
        end else begin
            in_q <= spi_in;
            for (int j = 0; j < NUM_SPI; j++) begin
                if (cfg_we && cfg_id == ID_W'(LOCAL_IDS + j)) begin
                    case (cfg_op)
                        CFG_ENABLE: en[j]    <= cfg_data[0];
                        CFG_PRIO:   prio[j]  <= cfg_data[PRIO_W-1:0];
                        CFG_ROUTE:  route[j] <= cfg_data[PE_W-1:0];
                        default: ;
                    endcase
                end
                // completion is accepted from any core, so a reroute cannot strand it
                for (int p = 0; p < NUM_PE; p++) begin
                    if (eoi[p] && eoi_id[p*ID_W +: ID_W] == ID_W'(LOCAL_IDS + j))
                        act[j] <= 1'b0;
                end
                for (int p = 0; p < NUM_PE; p++) begin
                    if (take[p] && take_id[p*ID_W +: ID_W] == ID_W'(LOCAL_IDS + j)) begin
                        pend[j] <= 1'b0;
                        act[j]  <= 1'b1;
                    end
                end
                if (spi_in[j] && !in_q[j]) pend[j] <= 1'b1;
            end
        end
    end

    assign elig_o  = pend & en & ~act;
    assign prio_o  = prio;
    assign route_o = route;

endmodule

// File: rtl/irq_arb.sv
module irq_arb import irq_dist_pkg::*; #(
    parameter int TOTAL = 64
) (
    input  logic [TOTAL-1:0]        elig,
    input  logic [TOTAL*PRIO_W-1:0] prio,
    output cand_t                   best_o
);
    // ascending scan with strict compare: ties keep the lower number
    always_comb begin
        best_o = '0;
        for (int k = 0; k < TOTAL; k++) begin
            if (elig[k] && (!best_o.valid || prio[k*PRIO_W +: PRIO_W] < best_o.prio)) begin
                best_o.valid = 1'b1;
                best_o.id    = ID_W'(k);
                best_o.prio  = prio[k*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_dist.sv
module irq_dist import irq_dist_pkg::*; #(
    parameter int NUM_PE  = 8,
    parameter int NUM_SPI = 32,
    localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int DW     = (NUM_PE > PRIO_W) ? NUM_PE : PRIO_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_op,
    input  logic [PE_W-1:0]          cfg_pe,
    input  logic [ID_W-1:0]          cfg_id,
    input  logic [DW-1:0]            cfg_data,
    input  logic [NUM_PE*PPI_IDS-1:0] ppi_in,
    input  logic [NUM_SPI-1:0]       spi_in,
    input  logic [NUM_PE-1:0]        ack,
    output logic [NUM_PE*ID_W-1:0]   ack_id,
    input  logic [NUM_PE-1:0]        eoi,
    input  logic [NUM_PE*ID_W-1:0]   eoi_id,
    output logic [NUM_PE-1:0]        irq
);
    localparam int TOTAL = LOCAL_IDS + NUM_SPI;
    localparam int IDX_W = $clog2(TOTAL);

    cfg_op_e                          op;
    logic [NUM_SPI-1:0]               s_elig;
    logic [NUM_SPI*PRIO_W-1:0]        s_prio;
    logic [NUM_SPI*PE_W-1:0]          s_route;
    logic [NUM_PE-1:0]                take;
    logic [NUM_PE*ID_W-1:0]           take_id;
    logic [NUM_PE-1:0][PRIO_W-1:0]    thr;

    assign op = cfg_op_e'(cfg_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr <= '1;
        end else if (cfg_we && op == CFG_THRESH) begin
            thr[cfg_pe] <= cfg_data[PRIO_W-1:0];
        end
    end

    irq_shared #(.NUM_PE(NUM_PE), .NUM_SPI(NUM_SPI), .PE_W(PE_W), .DW(DW)) u_shared (
        .clk, .rst, .cfg_we, .cfg_op(op), .cfg_id, .cfg_data, .spi_in,
        .take, .take_id, .eoi, .eoi_id,
        .elig_o(s_elig), .prio_o(s_prio), .route_o(s_route)
    );

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        logic [LOCAL_IDS-1:0]        l_elig;
        logic [LOCAL_IDS*PRIO_W-1:0] l_prio;
        logic [TOTAL-1:0]            elig;
        cand_t                       best_d, best_q;
        logic                        live;

        irq_bank #(.DW(DW)) u_bank (
            .clk, .rst, .cfg_we, .cfg_op(op),
            .cfg_sel(cfg_pe == PE_W'(p)), .sgi_tgt(cfg_data[p]),
            .cfg_id, .cfg_data,
            .ppi_in(ppi_in[p*PPI_IDS +: PPI_IDS]),
            .take(take[p]), .take_id(best_q.id),
            .eoi(eoi[p]), .eoi_id(eoi_id[p*ID_W +: ID_W]),
            .elig_o(l_elig), .prio_o(l_prio)
        );

        always_comb begin
            elig[LOCAL_IDS-1:0] = l_elig;
            for (int j = 0; j < NUM_SPI; j++)
                elig[LOCAL_IDS+j] = s_elig[j] && (s_route[j*PE_W +: PE_W] == PE_W'(p));
        end

        irq_arb #(.TOTAL(TOTAL)) u_arb (
            .elig(elig), .prio({s_prio, l_prio}), .best_o(best_d)
        );

        always_ff @(posedge clk) begin
            if (rst) best_q <= '0;
            else     best_q <= best_d;
        end

        // the registered winner is handed out only if it is still a candidate now
        assign live    = best_q.valid && elig[best_q.id[IDX_W-1:0]];
        assign take[p] = ack[p] && live;
        assign take_id[p*ID_W +: ID_W] = best_q.id;
        assign ack_id[p*ID_W +: ID_W]  = live ? best_q.id : SPURIOUS_ID;
        assign irq[p]  = live && (best_q.prio < thr[p]);
    end

endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk import irq_dist_pkg::*; #(
    parameter int NUM_PE  = 8,
    parameter int NUM_SPI = 32,
    localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int DW     = (NUM_PE > PRIO_W) ? NUM_PE : PRIO_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_we,
    input logic [2:0]             cfg_op,
    input logic [PE_W-1:0]        cfg_pe,
    input logic [DW-1:0]          cfg_data,
    input logic [NUM_PE-1:0]      ack,
    input logic [NUM_PE*ID_W-1:0] ack_id,
    input logic [NUM_PE-1:0]      irq
);
    for (genvar p = 0; p < NUM_PE; p++) begin : g_chk
        // R7
        id_range_chk: assert property (@(posedge clk) disable iff (rst)
            (ack_id[p*ID_W +: ID_W] == SPURIOUS_ID) ||
            (ack_id[p*ID_W +: ID_W] < ID_W'(LOCAL_IDS + NUM_SPI)));

        // R8
        irq_has_id_chk: assert property (@(posedge clk) disable iff (rst)
            irq[p] |-> ack_id[p*ID_W +: ID_W] != SPURIOUS_ID);

        // R6
        no_double_take_chk: assert property (@(posedge clk) disable iff (rst)
            (ack[p] && ack_id[p*ID_W +: ID_W] != SPURIOUS_ID)
            |=> ack_id[p*ID_W +: ID_W] != $past(ack_id[p*ID_W +: ID_W]));

        // R8
        zero_thresh_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_op == 3'(CFG_THRESH) && cfg_pe == PE_W'(p) && cfg_data == '0)
            |=> !irq[p]);
    end
endmodule

bind irq_dist irq_dist_chk #(.NUM_PE(NUM_PE), .NUM_SPI(NUM_SPI)) u_chk (.*);

// File: tb/sim_irq_dist.sv
module sim_irq_dist;
    localparam int NPE = 8;
    localparam int NSP = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_op = '0;
    logic [2:0]  cfg_pe = '0;
    logic [9:0]  cfg_id = '0;
    logic [7:0]  cfg_data = '0;
    logic [NPE*16-1:0] ppi_in = '0;
    logic [NSP-1:0]    spi_in = '0;
    logic [NPE-1:0]    ack = '0;
    logic [NPE*10-1:0] ack_id;
    logic [NPE-1:0]    eoi = '0;
    logic [NPE*10-1:0] eoi_id = '0;
    logic [NPE-1:0]    irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bit       l_pend[NPE][32], l_act[NPE][32], l_en[NPE][32];
    int       l_pri[NPE][32];
    bit       s_pend[NSP], s_act[NSP], s_en[NSP];
    int       s_pri[NSP], s_rt[NSP];
    int       thr[NPE];
    int       last_take[NPE];

    irq_dist #(.NUM_PE(NPE), .NUM_SPI(NSP)) u0 (.*);

    always #2 clk = ~clk;

    function automatic bit m_elig(int pe, int id);
        if (id < 32) return l_pend[pe][id] && l_en[pe][id] && !l_act[pe][id];
        return s_pend[id-32] && s_en[id-32] && !s_act[id-32] && s_rt[id-32] == pe;
    endfunction

    function automatic int m_pri(int pe, int id);
        return (id < 32) ? l_pri[pe][id] : s_pri[id-32];
    endfunction

    function automatic int m_best(int pe);
        int b = 1023;
        int bp = 256;
        for (int id = 0; id < 32 + NSP; id++)
            if (m_elig(pe, id) && m_pri(pe, id) < bp) begin
                b = id;
                bp = m_pri(pe, id);
            end
        return b;
    endfunction

    task automatic check(string tag, int actual, int expected);
        n_chk++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    function automatic int got_id(int pe);
        return int'(ack_id[pe*10 +: 10]);
    endfunction

    task automatic check_all(string req);
        for (int pe = 0; pe < NPE; pe++) begin
            int b = m_best(pe);
            int ei = (b != 1023 && m_pri(pe, b) < thr[pe]) ? 1 : 0;
            check($sformatf("%s core%0d ack_id", req, pe), got_id(pe), b);
            check($sformatf("%s core%0d irq", req, pe), int'(irq[pe]), ei);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(int op, int pe, int id, int data);
        cfg_we = 1'b1; cfg_op = 3'(op); cfg_pe = 3'(pe); cfg_id = 10'(id); cfg_data = 8'(data);
        step();
        cfg_we = 1'b0;
        case (op)
            0: if (id < 32) l_en[pe][id] = data[0]; else if (id < 32 + NSP) s_en[id-32] = data[0];
            1: if (id < 32) l_pri[pe][id] = data & 255; else if (id < 32 + NSP) s_pri[id-32] = data & 255;
            2: if (id >= 32 && id < 32 + NSP) s_rt[id-32] = data & (NPE - 1);
            3: if (id < 16) for (int q = 0; q < NPE; q++) if (data[q]) l_pend[q][id] = 1'b1;
            4: thr[pe] = data & 255;
            default: ;
        endcase
    endtask

    task automatic pulse_ppi(int pe, int k);
        ppi_in[pe*16 + k] = 1'b1;
        step();
        ppi_in[pe*16 + k] = 1'b0;
        l_pend[pe][16+k] = 1'b1;
    endtask

    task automatic pulse_spi(int j);
        spi_in[j] = 1'b1;
        step();
        spi_in[j] = 1'b0;
        s_pend[j] = 1'b1;
    endtask

    task automatic do_ack(int pe, string req);
        int e = m_best(pe);
        check($sformatf("%s core%0d ack value", req, pe), got_id(pe), e);
        ack[pe] = 1'b1;
        step();
        ack[pe] = 1'b0;
        if (e != 1023) begin
            if (e < 32) begin l_pend[pe][e] = 1'b0; l_act[pe][e] = 1'b1; end
            else begin s_pend[e-32] = 1'b0; s_act[e-32] = 1'b1; end
            last_take[pe] = e;
        end
        // R9: the number just taken is not offered on the following cycle
        check($sformatf("R9 core%0d after ack", pe), got_id(pe), 1023);
    endtask

    task automatic do_eoi(int pe, int id);
        eoi[pe] = 1'b1; eoi_id[pe*10 +: 10] = 10'(id);
        step();
        eoi[pe] = 1'b0;
        if (id < 32) l_act[pe][id] = 1'b0; else if (id < 32 + NSP) s_act[id-32] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R9: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4021);
        for (int pe = 0; pe < NPE; pe++) begin thr[pe] = 255; last_take[pe] = 0; end
        repeat (3) step();
        rst = 1'b0;
        step();
        // R12 reset state
        check_all("R12");
        check("R12 irq vector", int'(irq), 0);

        // R2 / R1 / R9: private line 0 of core 0 is number 16
        cfg(0, 0, 16, 1); cfg(1, 0, 16, 10);
        cfg(0, 1, 16, 1); cfg(1, 1, 16, 10);
        pulse_ppi(0, 0);
        check("R9 not yet visible", got_id(0), 1023);
        step();
        check("R1 private line maps to 16", got_id(0), 16);
        check("R2 core1 untouched", got_id(1), 1023);
        check_all("R2");

        // R3 software interrupt fan-out
        for (int pe = 0; pe < NPE; pe++) begin cfg(0, pe, 5, 1); cfg(1, pe, 5, 5); end
        cfg(3, 0, 5, 8'b0000_0101);
        step();
        check("R3 core0 got 5", got_id(0), 5);
        check("R3 core2 got 5", got_id(2), 5);
        check("R3 core1 not targeted", got_id(1), 1023);
        cfg(3, 0, 20, 8'hFF);
        step();
        check_all("R3 number 20 ignored");

        // R5 tie goes to lower number; R6 ack/active flow
        cfg(0, 0, 7, 1); cfg(1, 0, 7, 5);
        cfg(3, 0, 7, 8'b0000_0001);
        step();
        check("R5 tie lower number", got_id(0), 5);
        do_ack(0, "R6");
        step();
        check("R6 next best after ack", got_id(0), 7);
        do_ack(0, "R6");
        step();
        check("R5 lower urgency last", got_id(0), 16);
        cfg(3, 0, 5, 8'b0000_0001);
        step();
        check("R6 active not candidate", got_id(0), 16);
        do_eoi(0, 5);
        step();
        check("R6 completion re-enables", got_id(0), 5);
        check_all("R6");

        // R7 spurious acknowledge
        do_ack(4, "R7");
        step();
        check_all("R7 no state change");

        // R4 routing and R11 completion after reroute
        cfg(0, 0, 40, 1); cfg(1, 0, 40, 3); cfg(2, 0, 40, 3);
        pulse_spi(8);
        step();
        check("R1 shared line 8 maps to 40", got_id(3), 40);
        check("R4 other core blind", got_id(6), 1023);
        cfg(2, 0, 40, 6);
        step();
        check("R4 rerouted", got_id(6), 40);
        check("R4 old target cleared", got_id(3), 1023);
        do_ack(6, "R4");
        cfg(2, 0, 40, 3);
        do_eoi(3, 40);
        pulse_spi(8);
        step();
        check("R11 completion from other core", got_id(3), 40);

        // R8 threshold
        cfg(4, 3, 0, 3);
        check("R8 equal priority masked", int'(irq[3]), 0);
        cfg(4, 3, 0, 4);
        check("R8 below threshold", int'(irq[3]), 1);
        cfg(4, 3, 0, 0);
        check("R8 zero threshold", int'(irq[3]), 0);
        cfg(4, 3, 0, 255);

        // R10 enable gate and out-of-range numbers
        cfg(0, 0, 40, 0);
        step();
        check("R10 disabled hidden", got_id(3), 1023);
        cfg(0, 0, 100, 1);
        step();
        check_all("R10");

        // constrained random mix
        for (int it = 0; it < 600; it++) begin
            int r = $urandom % 10;
            int pe = $urandom % NPE;
            int id = ($urandom % 8 == 0) ? 64 + $urandom % 64 : $urandom % 64;
            case (r)
                0: cfg(0, pe, id, ($urandom % 4 != 0) ? 1 : 0);
                1: cfg(1, pe, id, $urandom % 8);
                2: cfg(2, pe, 32 + $urandom % NSP, $urandom % 256);
                3: cfg(3, pe, $urandom % 32, $urandom % 256);
                4: cfg(4, pe, 0, ($urandom % 3 == 0) ? $urandom % 8 : 255);
                5: pulse_ppi(pe, $urandom % 16);
                6: pulse_spi($urandom % NSP);
                7, 8: do_ack(pe, "R6");
                default: do_eoi(pe, ($urandom % 2 == 0) ? last_take[pe] : id);
            endcase
            step();
            check_all("R5 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule